// File: doc/BRIEF.md
# Floating-Point Rounding-Mode Legality Decoder

This block sits in the decode stage of an in-order core. It looks at one 32-bit instruction word together with the current dynamic rounding-mode register. For floating-point arithmetic and conversion encodings, it decides whether the instruction is legal. When it is, it produces the rounding mode the datapath should use. When it is not, it raises an illegal-instruction flag for the trap logic. Words with any other major opcode pass through with every output low, so the block can run alongside the decoders for other opcodes.

Instructions fall into five classes:

- **Rounding:** the instruction rounds its result.
- **Exact:** the instruction is a conversion that never rounds but still carries a mode field.
- **Selector:** funct3 picks a sub-operation.
- **Fixed-zero:** the instruction is a move into the floating-point register file, and funct3 must be zero.
- **Unrecognised:** the encoding is not known.

Exact conversions apply the same legality rules as rounding instructions, including the dynamic lookup. Any legal mode is accepted for them. Selector instructions never consult the dynamic register.

A parameter selects either a purely combinational path or a single output register.

Top module: `fprm_legal_dec`

## Requirements
- R1: Only words with bits [6:0] = 1010011 are decoded. Any other opcode gives valid_o = 0, illegal_o = 0 and rm_o = 000.
- R2: For a rounding instruction (for example funct7 0000000, single-precision add), a mode field in bits [14:12] of 000 to 100 is legal, and rm_o equals that field.
- R3: A mode field of 101 or 110 on a rounding or exact instruction raises illegal_o.
- R4: A mode field of 111 takes the mode from dyn_rm_i. Register values 000 to 100 give a legal instruction with rm_o equal to the register. Values 101 to 111 raise illegal_o.
- R5: Exact conversions follow R2 to R4 unchanged, and every legal resolved mode is accepted. These are single-to-double widening (funct7 0100001, rs2 00000) and integer-to-double (funct7 1101001, rs2 00000 or 00001). The word 0x42031ad3 is legal with rm_o = 001.
- R6: The integer-to-single move (funct7 1111000, rs2 00000) is legal only with funct3 = 000, whatever dyn_rm_i holds. On acceptance rm_o = 000.
- R7: Selector groups never consult dyn_rm_i and report rm_o = 000. Their legal funct3 values are:
  - sign-inject (funct7 001000x): 000, 001 or 010
  - min/max (001010x): 000 or 001
  - compare (101000x): 000, 001 or 010
  - single move-out/classify (1110000, rs2 0): 000 or 001
  - double classify (1110001, rs2 0): 001 only
- R8: Any unrecognised funct7/rs2 combination raises illegal_o for every mode field. Examples are funct7 0000010, and funct7 1100000 with rs2 00010.
- R9: Whenever illegal_o is 1, valid_o is 0 and rm_o is 000. valid_o and illegal_o are never both 1.
- R10: With OUT_REG = 1, outputs appear one clock after the inputs, and reset clears all outputs to 0. With OUT_REG = 0, outputs follow the inputs in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset |
| insn_i | input | 32 | Instruction word under decode |
| dyn_rm_i | input | 3 | Current dynamic rounding-mode register |
| rm_o | output | 3 | Resolved rounding mode, 000 unless legal and rounding/exact |
| valid_o | output | 1 | Word is a legal decoded floating-point instruction |
| illegal_o | output | 1 | Word must raise an illegal-instruction trap |

## Verification
The bench builds two copies side by side. The instance with OUT_REG = 1 is scored through a queue one clock after each stimulus, which exercises the register stage and its reset values. The OUT_REG = 0 instance is compared in the same cycle, so the purely combinational variant is covered too. The full sweep of all mode-field values against all register values is run on a rounding add, two exact conversions, the integer move and a selector group. This reaches every mix of static, dynamic and reserved modes across both variants.

// File: rtl/fprm_pkg.sv
package fprm_pkg;
    localparam int INSN_W   = 32;
    localparam int RM_W     = 3;
    localparam int F7_W     = 7;
    localparam int RS2_W    = 5;
    localparam int OPC_W    = 7;
    localparam int NUM_F3   = 1 << RM_W;
    localparam logic [RM_W-1:0]  RM_MAX_LEGAL = 3'b100;
    localparam logic [RM_W-1:0]  RM_DYN       = 3'b111;
    localparam logic [OPC_W-1:0] OPC_OPFP     = 7'b1010011;

    typedef enum logic [2:0] {
        CLS_BAD   = 3'd0,
        CLS_ROUND = 3'd1,
        CLS_EXACT = 3'd2,
        CLS_SEL   = 3'd3,
        CLS_ZERO  = 3'd4
    } fp_cls_e;

    typedef struct packed {
        logic            valid;
        logic            illegal;
        logic [RM_W-1:0] rm;
    } dec_out_t;
endpackage

// File: rtl/fprm_op_class.sv
module fprm_op_class
    import fprm_pkg::*;
(
    input  logic [F7_W-1:0]   funct7_i,
    input  logic [RS2_W-1:0]  rs2_i,
    output fp_cls_e           cls_o,
    output logic [NUM_F3-1:0] sel_mask_o
);
    localparam logic [NUM_F3-1:0] MASK_3OP = NUM_F3'(3'b111);
    localparam logic [NUM_F3-1:0] MASK_2OP = NUM_F3'(2'b11);
    localparam logic [NUM_F3-1:0] MASK_F1  = NUM_F3'(2'b10);

    logic rs2_zero, rs2_int;
    assign rs2_zero = (rs2_i == '0);
    assign rs2_int  = (rs2_i[RS2_W-1:1] == '0);

    always_comb begin
        cls_o      = CLS_BAD;
        sel_mask_o = '0;
        case (funct7_i)
            7'h00, 7'h01, 7'h04, 7'h05,
            7'h08, 7'h09, 7'h0C, 7'h0D: cls_o = CLS_ROUND;
            7'h2C, 7'h2D: if (rs2_zero) cls_o = CLS_ROUND;
            7'h20:        if (rs2_i == 5'd1) cls_o = CLS_ROUND;
            7'h21:        if (rs2_zero) cls_o = CLS_EXACT;
            7'h60, 7'h61, 7'h68: if (rs2_int) cls_o = CLS_ROUND;
            7'h69:        if (rs2_int) cls_o = CLS_EXACT;
            7'h10, 7'h11, 7'h50, 7'h51: begin
                cls_o      = CLS_SEL;
                sel_mask_o = MASK_3OP;
            end
            7'h14, 7'h15: begin
                cls_o      = CLS_SEL;
                sel_mask_o = MASK_2OP;
            end
            7'h70: if (rs2_zero) begin
                cls_o      = CLS_SEL;
                sel_mask_o = MASK_2OP;
            end
            7'h71: if (rs2_zero) begin
                cls_o      = CLS_SEL;
                sel_mask_o = MASK_F1;
            end
            7'h78: if (rs2_zero) cls_o = CLS_ZERO;
            default: cls_o = CLS_BAD;
        endcase
    end
endmodule

// File: rtl/fprm_rm_resolve.sv
module fprm_rm_resolve
    import fprm_pkg::*;
(
    input  logic [RM_W-1:0] field_i,
    input  logic [RM_W-1:0] dyn_i,
    output logic [RM_W-1:0] rm_o,
    output logic            ok_o
);
    logic [RM_W-1:0] pick;
    assign pick = (field_i == RM_DYN) ? dyn_i : field_i;

    always_comb begin
        ok_o = (pick <= RM_MAX_LEGAL);
        rm_o = ok_o ? pick : '0;
    end
endmodule

// File: rtl/fprm_legal_dec.sv
module fprm_legal_dec
    import fprm_pkg::*;
#(
    parameter bit OUT_REG = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [INSN_W-1:0] insn_i,
    input  logic [RM_W-1:0]   dyn_rm_i,
    output logic [RM_W-1:0]   rm_o,
    output logic              valid_o,
    output logic              illegal_o
);
    logic [OPC_W-1:0] opcode;
    logic [RM_W-1:0]  funct3;
    logic [F7_W-1:0]  funct7;
    logic [RS2_W-1:0] rs2;
    logic             unused_fields;

    assign opcode        = insn_i[OPC_W-1:0];
    assign funct3        = insn_i[14:12];
    assign rs2           = insn_i[24:20];
    assign funct7        = insn_i[INSN_W-1:INSN_W-F7_W];
    assign unused_fields = ^{insn_i[19:15], insn_i[11:7]};

    fp_cls_e           cls;
    logic [NUM_F3-1:0] sel_mask;
    logic [RM_W-1:0]   res_rm;
    logic              res_ok;

    fprm_op_class u_class (
        .funct7_i   (funct7),
        .rs2_i      (rs2),
        .cls_o      (cls),
        .sel_mask_o (sel_mask)
    );

    fprm_rm_resolve u_resolve (
        .field_i (funct3),
        .dyn_i   (dyn_rm_i),
        .rm_o    (res_rm),
        .ok_o    (res_ok)
    );

    dec_out_t out_d, out_q;

    always_comb begin
        out_d = '0;
        if (opcode == OPC_OPFP) begin
            case (cls)
                CLS_ROUND, CLS_EXACT: begin
                    out_d.valid   = res_ok;
                    out_d.illegal = !res_ok;
                    out_d.rm      = res_ok ? res_rm : '0;
                end
                CLS_SEL: begin
                    out_d.valid   = sel_mask[funct3];
                    out_d.illegal = !sel_mask[funct3];
                end
                CLS_ZERO: begin
                    out_d.valid   = (funct3 == '0);
                    out_d.illegal = (funct3 != '0);
                end
                default: out_d.illegal = 1'b1;
            endcase
        end
    end

    generate
        if (OUT_REG) begin : g_reg
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) out_q <= '0;
                else        out_q <= out_d;
            end
        end else begin : g_comb
            assign out_q = out_d;
        end
    endgenerate

    assign rm_o      = out_q.rm;
    assign valid_o   = out_q.valid;
    assign illegal_o = out_q.illegal;
endmodule

// File: rtl/fprm_legal_chk.sv
module fprm_legal_chk
    import fprm_pkg::*;
#(
    parameter bit OUT_REG = 1'b1
) (
    input logic              clk,
    input logic              rst_n,
    input logic [INSN_W-1:0] insn_i,
    input logic [RM_W-1:0]   dyn_rm_i,
    input logic [RM_W-1:0]   rm_o,
    input logic              valid_o,
    input logic              illegal_o
);
    logic [INSN_W-1:0] insn_q;
    logic [RM_W-1:0]   dyn_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            insn_q <= '0;
            dyn_q  <= '0;
        end else begin
            insn_q <= insn_i;
            dyn_q  <= dyn_rm_i;
        end
    end

    logic [INSN_W-1:0] w;
    logic [RM_W-1:0]   d;
    assign w = OUT_REG ? insn_q : insn_i;
    assign d = OUT_REG ? dyn_q  : dyn_rm_i;

    logic opfp;
    assign opfp = (w[6:0] == OPC_OPFP);

    // R1
    other_opc_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !opfp |-> (!valid_o && !illegal_o && rm_o == '0));
    // R3
    reserved_static_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (opfp && w[31:25] == 7'h00 && (w[14:12] == 3'b101 || w[14:12] == 3'b110)) |-> illegal_o);
    // R4
    dyn_resolve_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (opfp && w[31:25] == 7'h00 && w[14:12] == 3'b111 && d <= 3'b100) |-> (valid_o && rm_o == d));
    // R5
    exact_widen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (opfp && w[31:25] == 7'h21 && w[24:20] == 5'd0 && w[14:12] <= 3'b100) |-> (valid_o && rm_o == w[14:12]));
    // R6
    move_in_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (opfp && w[31:25] == 7'h78 && w[24:20] == 5'd0 && w[14:12] != 3'b000) |-> illegal_o);
    // R9
    illegal_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_o |-> (!valid_o && rm_o == '0));
endmodule

bind fprm_legal_dec fprm_legal_chk #(.OUT_REG(OUT_REG)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .insn_i    (insn_i),
    .dyn_rm_i  (dyn_rm_i),
    .rm_o      (rm_o),
    .valid_o   (valid_o),
    .illegal_o (illegal_o)
);

// File: tb/fprm_legal_dec_test.sv
module fprm_legal_dec_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] insn = 32'h0;
    logic [2:0]  dyn = 3'h0;
    logic [2:0]  rm_r, rm_c;
    logic        v_r, v_c, il_r, il_c;
    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    fprm_legal_dec #(.OUT_REG(1'b1)) uut (
        .clk(clk), .rst_n(rst_n), .insn_i(insn), .dyn_rm_i(dyn),
        .rm_o(rm_r), .valid_o(v_r), .illegal_o(il_r));
    fprm_legal_dec #(.OUT_REG(1'b0)) uut_c (
        .clk(clk), .rst_n(rst_n), .insn_i(insn), .dyn_rm_i(dyn),
        .rm_o(rm_c), .valid_o(v_c), .illegal_o(il_c));

    typedef struct {
        logic [31:0] w;
        logic        v;
        logic        il;
        logic [2:0]  rm;
        string       tag;
    } item_t;
    item_t sb[$];

    function automatic void model(input logic [31:0] w, input logic [2:0] d,
                                  output logic v, output logic il,
                                  output logic [2:0] r, output string tag);
        logic [6:0] f7;
        logic [4:0] rs2;
        logic [2:0] f3, m;
        int kind;
        logic [7:0] mask;
        f7 = w[31:25]; rs2 = w[24:20]; f3 = w[14:12];
        v = 1'b0; il = 1'b0; r = 3'b000; tag = "R1"; kind = 0; mask = 8'h00;
        if (w[6:0] != 7'b1010011) return;
        case (f7)
            7'h00, 7'h01, 7'h04, 7'h05, 7'h08, 7'h09, 7'h0C, 7'h0D: kind = 1;
            7'h2C, 7'h2D: kind = (rs2 == 0) ? 1 : 0;
            7'h20: kind = (rs2 == 1) ? 1 : 0;
            7'h21: kind = (rs2 == 0) ? 2 : 0;
            7'h60, 7'h61, 7'h68: kind = (rs2 < 2) ? 1 : 0;
            7'h69: kind = (rs2 < 2) ? 2 : 0;
            7'h10, 7'h11, 7'h50, 7'h51: begin kind = 3; mask = 8'h07; end
            7'h14, 7'h15: begin kind = 3; mask = 8'h03; end
            7'h70: if (rs2 == 0) begin kind = 3; mask = 8'h03; end
            7'h71: if (rs2 == 0) begin kind = 3; mask = 8'h02; end
            7'h78: kind = (rs2 == 0) ? 4 : 0;
            default: kind = 0;
        endcase
        case (kind)
            1, 2: begin
                m = (f3 == 3'b111) ? d : f3;
                tag = (kind == 2) ? "R5" : (f3 == 3'b111) ? "R4" :
                      (f3 > 3'b100) ? "R3" : "R2";
                if (m <= 3'b100) begin v = 1'b1; r = m; end
                else il = 1'b1;
            end
            3: begin tag = "R7"; v = mask[f3]; il = !mask[f3]; end
            4: begin tag = "R6"; v = (f3 == 0); il = (f3 != 0); end
            default: begin tag = "R8"; il = 1'b1; end
        endcase
        if (il) tag = {tag, "/R9"};
    endfunction

    task automatic cmp(input string tag, input logic [31:0] w,
                       input logic v, input logic il, input logic [2:0] r,
                       input logic ev, input logic eil, input logic [2:0] er);
        checks++;
        if (v !== ev || il !== eil || r !== er) begin
            failures++;
            $display("FAIL %s insn=%h actual v=%b il=%b rm=%b expected v=%b il=%b rm=%b",
                     tag, w, v, il, r, ev, eil, er);
        end
    endtask

    task automatic drive(input logic [31:0] w, input logic [2:0] d);
        item_t it;
        logic ev, eil;
        logic [2:0] er;
        string tag;
        @(negedge clk);
        insn = w;
        dyn  = d;
        model(w, d, ev, eil, er, tag);
        #1;
        cmp({tag, " R10 comb"}, w, v_c, il_c, rm_c, ev, eil, er);
        it.w = w; it.v = ev; it.il = eil; it.rm = er; it.tag = {tag, " R10 reg"};
        sb.push_back(it);
    endtask

    initial begin : monitor
        item_t it;
        forever begin
            @(posedge clk);
            #1;
            if (sb.size() > 0) begin
                it = sb.pop_front();
                cmp(it.tag, it.w, v_r, il_r, rm_r, it.v, it.il, it.rm);
            end
        end
    end

    function automatic logic [31:0] with_f3(input logic [31:0] base, input int f3);
        logic [31:0] w;
        w = base;
        w[14:12] = 3'(f3);
        return w;
    endfunction

    initial begin : driver
        insn = 32'h0000_0053;
        dyn  = 3'b101;
        repeat (2) @(negedge clk);
        // R10 reset state of the registered copy
        cmp("R10 reset", insn, v_r, il_r, rm_r, 1'b0, 1'b0, 3'b000);
        rst_n = 1'b1;
        @(negedge clk);
        // R5: the specific widening word with rtz must be legal
        drive(32'h4203_1ad3, 3'b111);
        for (int f = 0; f < 8; f++) begin
            for (int d = 0; d < 8; d++) begin
                drive(with_f3(32'h0000_0053, f), 3'(d)); // R2 R3 R4 add
                drive(with_f3(32'h4200_0053, f), 3'(d)); // R5 widen
                drive(with_f3(32'hD200_0053, f), 3'(d)); // R5 int-to-double
                drive(with_f3(32'hF000_0053, f), 3'(d)); // R6 move in
                drive(with_f3(32'h2000_0053, f), 3'(d)); // R7 sign inject
            end
        end
        drive(32'hE000_0053, 3'b101);   // R7 move-out, reserved dyn ignored
        drive(32'hE200_1053, 3'b110);   // R7 double classify legal
        drive(32'hE200_0053, 3'b000);   // R7 double move-out illegal
        drive(32'h2800_2053, 3'b000);   // R7 min/max funct3 010 illegal
        drive(32'h0400_0053, 3'b000);   // R8 unknown funct7
        drive(32'hC020_0053, 3'b000);   // R8 rs2 out of range
        drive(32'h4010_7053, 3'b011);   // R4 narrowing with dyn
        drive(32'h0000_0013, 3'b000);   // R1 other opcode
        drive(32'h0000_5033, 3'b111);   // R1 other opcode
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : watchdog
        #(1_000_000);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL R10 watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule